// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A host writes a byte into a transmit holding register. The transmitter moves that byte into its shift register and sends it on the serial output as a framed character. On the other side, the receiver watches the serial input, rebuilds incoming characters and places each one in a receive holding register. The host reads that register through the same data port that it writes to. All bit timing comes from an external enable that pulses sixteen times per bit period. Generating that enable is left to a baud-rate block outside this one.

Four control inputs set the frame format while the port runs:
- a 7-bit or 8-bit character;
- parity present or absent;
- even or odd parity;
- one or two stop bits.

Each direction has its own enable. A global enable clears the whole port while it is low. The block gives single-cycle event pulses to a companion status block: a character landed in the receive register, the transmit register was emptied, and the final stop bit was shifted out. It also gives parity and framing error flags, which are valid with the receive pulse.

Top module: `async_xcvr`

## Requirements
- R1: While no character is in flight, the serial output is held high. Each character begins with one low start bit, followed by its data bits least-significant first. `char7`=0 sends 8 data bits and `char7`=1 sends 7.
- R2: With `par_on`=1, a parity bit follows the data. With `par_odd`=0 it makes the count of ones in data plus parity even, and with `par_odd`=1 it makes that count odd. With `par_on`=0 no parity bit is sent.
- R3: The frame ends with one high stop bit (`stop_two`=0) or two (`stop_two`=1). Each bit lasts 16 `os_tick` pulses. `tx_done` pulses once when the last stop bit ends, and the line is high in that cycle.
- R4: A host write loads the transmit holding register. The register is moved into the shift register only when the shifter is idle and the holding register is full. `tx_empty` pulses once per move. A byte written during a frame goes out directly after that frame.
- R5: While `tx_on`=0, no byte is moved to the shifter and the line stays high. A written byte is kept and goes out once `tx_on` returns to 1.
- R6: The receiver takes a frame of the configured format. In the cycle that `rx_load` pulses, `host_rdata` holds the received byte. With `char7`=1, bit 7 of that byte reads 0.
- R7: `rx_perr` pulses with `rx_load` when parity is enabled and the received parity bit does not match the selected sense. It never pulses while parity is disabled.
- R8: `rx_ferr` pulses with `rx_load` when the first stop bit is sampled low. Neither error flag is ever high without `rx_load`.
- R9: A low level on the serial input that has returned high by the middle of the start bit is discarded, and no character is produced. The receiver only starts on a high-to-low change.
- R10: While `rx_on`=0, incoming frames are ignored: there is no `rx_load`, and `host_rdata` is unchanged.
- R11: While `port_on`=0, the serial output goes high in the next cycle. Any frame in flight and any pending transmit byte are dropped, and `host_rdata` is cleared to 0.
- R12: A host write changes only the transmit side. `host_rdata` keeps the last received byte until the next `rx_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit |
| port_on | input | 1 | Global enable; low clears the port |
| tx_on | input | 1 | Transmit direction enable |
| rx_on | input | 1 | Receive direction enable |
| char7 | input | 1 | 0: 8-bit characters, 1: 7-bit characters |
| par_on | input | 1 | Parity bit present |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| stop_two | input | 1 | 0: one stop bit, 1: two stop bits |
| host_wr | input | 1 | Write strobe to the shared data port |
| host_wdata | input | 8 | Byte written to the transmit holding register |
| host_rdata | output | 8 | Receive holding register, read through the same port |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_load | output | 1 | Pulse: character moved into the receive register |
| tx_empty | output | 1 | Pulse: transmit holding register moved to the shifter |
| tx_done | output | 1 | Pulse: last stop bit finished |
| rx_perr | output | 1 | Parity error, valid with rx_load |
| rx_ferr | output | 1 | Framing error, valid with rx_load |

## Verification
The bench sweeps all sixteen frame formats against bytes with sparse, dense and alternating ones. It checks every transmitted bit at mid-period and every received byte. A design that placed the parity bit at a fixed position would corrupt 7-bit frames. A parity generator with the wrong sense would fail half of the bytes, and a receiver that did not mask bit 7 would leak the parity bit into 7-bit data. Targeted cases cover deliberately bad parity and a low stop bit, which a design that checked errors at the wrong moment would miss or report twice. They also cover a glitch shorter than half a bit, which a receiver without the mid-start recheck would turn into a phantom character. Further cases cover a byte written while a frame is in flight, which must follow without loss, a direction disabled while stimulus is present, and the global enable dropped mid-frame. A port that did not flush would still send the stale byte.

// File: rtl/async_xcvr.sv
module async_xcvr #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       port_on,
  input  logic       tx_on,
  input  logic       rx_on,
  input  logic       char7,
  input  logic       par_on,
  input  logic       par_odd,
  input  logic       stop_two,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_load,
  output logic       tx_empty,
  output logic       tx_done,
  output logic       rx_perr,
  output logic       rx_ferr
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  // transmit side
  logic [7:0]    hold;
  logic          hold_full;
  logic          tbusy;
  logic [11:0]   tsh;
  logic [3:0]    tleft;
  logic [CW-1:0] tcnt;
  logic [11:0]   tframe;
  logic [3:0]    tlen;
  logic [7:0]    dmask;
  logic          tpar;
  logic          tgo;

  assign dmask = char7 ? 8'h7F : 8'hFF;
  assign tpar  = (^(hold & dmask)) ^ par_odd;
  assign tlen  = 4'd10 - {3'd0, char7} + {3'd0, par_on} + {3'd0, stop_two};
  assign tgo   = tx_on && hold_full && !tbusy;
  assign txd   = tbusy ? tsh[0] : 1'b1;

  always_comb begin
    tframe    = '1;
    tframe[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (!(char7 && i == 7)) tframe[i+1] = hold[i];
    if (par_on) tframe[char7 ? 8 : 9] = tpar;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0; hold_full <= 1'b0; tbusy <= 1'b0; tsh <= '1;
      tleft <= '0; tcnt <= '0; tx_empty <= 1'b0; tx_done <= 1'b0;
    end else if (!port_on) begin
      hold <= '0; hold_full <= 1'b0; tbusy <= 1'b0; tsh <= '1;
      tleft <= '0; tcnt <= '0; tx_empty <= 1'b0; tx_done <= 1'b0;
    end else begin
      tx_empty <= tgo;
      tx_done  <= 1'b0;
      if (tgo) begin
        tsh <= tframe; tleft <= tlen; tcnt <= '0;
        tbusy <= 1'b1; hold_full <= 1'b0;
      end else if (tbusy && os_tick) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == LAST) begin
          tsh   <= {1'b1, tsh[11:1]};
          tleft <= tleft - 1'b1;
          if (tleft == 4'd1) begin
            tbusy   <= 1'b0;
            tx_done <= 1'b1;
          end
        end
      end
      if (host_wr) begin
        hold      <= host_wdata;
        hold_full <= 1'b1;
      end
    end
  end

  // receive side
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
  rx_state_t     rst;
  logic [1:0]    rsync;
  logic          rs;
  logic          rarm;
  logic [CW-1:0] rcnt;
  logic [3:0]    ridx;
  logic [7:0]    rdat;
  logic [7:0]    rbuf;
  logic          rpar;
  logic [3:0]    rdlen;

  assign rs         = rsync[1];
  assign rdlen      = char7 ? 4'd7 : 4'd8;
  assign host_rdata = rbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync <= 2'b11; rst <= RX_IDLE; rarm <= 1'b0; rcnt <= '0; ridx <= '0;
      rdat <= '0; rbuf <= '0; rpar <= 1'b0;
      rx_load <= 1'b0; rx_perr <= 1'b0; rx_ferr <= 1'b0;
    end else if (!port_on) begin
      rsync <= 2'b11; rst <= RX_IDLE; rarm <= 1'b0; rcnt <= '0; ridx <= '0;
      rdat <= '0; rbuf <= '0; rpar <= 1'b0;
      rx_load <= 1'b0; rx_perr <= 1'b0; rx_ferr <= 1'b0;
    end else begin
      rsync   <= {rsync[0], rxd};
      rx_load <= 1'b0;
      rx_perr <= 1'b0;
      rx_ferr <= 1'b0;
      if (!rx_on) begin
        rst  <= RX_IDLE;
        rarm <= 1'b0;
      end else begin
        case (rst)
          RX_IDLE: begin
            if (rs) rarm <= 1'b1;
            else if (os_tick && rarm) begin
              rst  <= RX_START;
              rcnt <= '0;
              rarm <= 1'b0;
            end
          end
          RX_START: if (os_tick) begin
            rcnt <= rcnt + 1'b1;
            if (rcnt == MID) begin
              rcnt <= '0;
              if (rs) begin
                rst  <= RX_IDLE;
                rarm <= 1'b1;
              end else begin
                rst  <= RX_BITS;
                ridx <= '0;
                rdat <= '0;
              end
            end
          end
          RX_BITS: if (os_tick) begin
            rcnt <= rcnt + 1'b1;
            if (rcnt == LAST) begin
              ridx <= ridx + 1'b1;
              if (ridx < rdlen) rdat[ridx[2:0]] <= rs;
              else if (par_on && ridx == rdlen) rpar <= rs;
              else begin
                rbuf    <= rdat;
                rx_load <= 1'b1;
                rx_ferr <= !rs;
                rx_perr <= par_on && ((^rdat) ^ rpar ^ par_odd);
                rarm    <= rs;
                rst     <= RX_IDLE;
              end
            end
          end
          default: rst <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_xcvr_chk.sv
module async_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_on,
  input logic       tx_on,
  input logic       char7,
  input logic       par_on,
  input logic       txd,
  input logic [7:0] host_rdata,
  input logic       rx_load,
  input logic       tx_empty,
  input logic       tx_done,
  input logic       rx_perr,
  input logic       rx_ferr
);
  AST_LOAD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> !txd); // R1
  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd); // R3
  AST_NO_LOAD_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_on) |-> !tx_empty); // R5
  AST_LEN7_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && char7) |-> !host_rdata[7]); // R6
  AST_PERR_NEEDS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_perr |-> $past(par_on)); // R7
  AST_ERR_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_perr || rx_ferr) |-> rx_load); // R8
  AST_OFF_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !port_on |=> (txd && !rx_load && host_rdata == 8'h00)); // R11
endmodule

bind async_xcvr async_xcvr_chk chk_i (.*);

// File: tb/async_xcvr_test.sv
module async_xcvr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b1;
  logic port_on = 1'b1, tx_on = 1'b1, rx_on = 1'b1;
  logic char7 = 1'b0, par_on = 1'b0, par_odd = 1'b0, stop_two = 1'b0;
  logic host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic txd;
  logic rxd = 1'b1;
  logic rx_load, tx_empty, tx_done, rx_perr, rx_ferr;

  int checks = 0, errors = 0;
  int div = 1;
  int n_rx = 0, n_txe = 0, n_txd = 0;
  logic [7:0] got_rx;
  logic got_pe, got_fe;
  bit finished = 0;

  always #2 clk = ~clk;

  async_xcvr uut (.*);

  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % div;
      os_tick = (c == 0);
    end
  end

  always @(negedge clk) begin
    if (rx_load) begin n_rx++; got_rx = host_rdata; got_pe = rx_perr; got_fe = rx_ferr; end
    if (tx_empty) n_txe++;
    if (tx_done) n_txd++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic done_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    done_run();
  end

  function automatic int dlen(); return char7 ? 7 : 8; endfunction
  function automatic int nbits(); return 1 + dlen() + int'(par_on) + 1 + int'(stop_two); endfunction

  function automatic logic ebit(input logic [7:0] d, input int k, input bit flip, input bit bad_stop);
    int ones = 0;
    int dl = dlen();
    for (int i = 0; i < dl; i++) ones += int'(d[i]);
    if (k == 0) return 1'b0;
    if (k <= dl) return d[k-1];
    if (par_on && k == dl + 1) return logic'((ones % 2) ^ int'(par_odd) ^ int'(flip));
    if (k == dl + 1 + int'(par_on)) return !bad_stop;
    return 1'b1;
  endfunction

  task automatic hw(input logic [7:0] d);
    @(negedge clk); host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic cap_tx(input logic [7:0] d);
    int w = 0;
    while (txd && w < 400 * div) begin @(negedge clk); w++; end
    chk(!txd, "R1 start seen", int'(txd), 0);
    repeat (8 * div) @(negedge clk);
    for (int k = 0; k < nbits(); k++) begin
      logic e;
      e = ebit(d, k, 0, 0);
      if (k <= dlen()) chk(txd === e, "R1 tx bit", int'(txd), int'(e));
      else if (par_on && k == dlen() + 1) chk(txd === e, "R2 parity bit", int'(txd), int'(e));
      else chk(txd === e, "R3 stop bit", int'(txd), int'(e));
      if (k != nbits() - 1) repeat (16 * div) @(negedge clk);
    end
  endtask

  task automatic send_rx(input logic [7:0] d, input bit flip, input bit bad_stop);
    for (int k = 0; k < nbits(); k++) begin
      @(negedge clk); rxd = ebit(d, k, flip, bad_stop);
      repeat (16 * div - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (48 * div) @(negedge clk);
  endtask

  task automatic tx_one(input logic [7:0] d);
    int t0;
    t0 = n_txd;
    hw(d);
    cap_tx(d);
    repeat (12 * div) @(negedge clk);
    chk(n_txd == t0 + 1, "R3 tx_done once", n_txd - t0, 1);
  endtask

  task automatic rx_one(input logic [7:0] d, input bit flip, input bit bad_stop);
    int r0;
    logic [7:0] e;
    r0 = n_rx;
    e = char7 ? (d & 8'h7F) : d;
    send_rx(d, flip, bad_stop);
    chk(n_rx == r0 + 1, "R6 rx_load once", n_rx - r0, 1);
    chk(got_rx == e, "R6 rx byte", got_rx, e);
    chk(got_pe == (flip && par_on), "R7 parity flag", got_pe, flip && par_on);
    chk(got_fe == bad_stop, "R8 framing flag", got_fe, bad_stop);
  endtask

  initial begin
    logic [7:0] pats [8];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01, 8'h3C, 8'hC3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1 reset idle high", int'(txd), 1);
    chk(host_rdata == 8'h00, "R11 reset rdata", host_rdata, 0);
    chk(n_rx == 0 && n_txe == 0 && n_txd == 0, "R4 no reset events", n_rx + n_txe + n_txd, 0);

    for (int cfg = 0; cfg < 16; cfg++) begin
      char7 = cfg[0]; par_on = cfg[1]; par_odd = cfg[2]; stop_two = cfg[3];
      for (int p = 0; p < 8; p++) begin
        tx_one(pats[p]);
        rx_one(pats[p], 0, 0);
      end
      if (par_on) rx_one(8'h96, 1, 0);
      rx_one(8'h69, 0, 1);
    end

    char7 = 0; par_on = 1; par_odd = 1; stop_two = 1;
    div = 3;
    repeat (4) @(negedge clk);
    tx_one(8'hB7);
    rx_one(8'h4E, 0, 0);
    div = 1;
    repeat (4) @(negedge clk);

    // R12: writing does not touch the receive register
    char7 = 0; par_on = 0; par_odd = 0; stop_two = 0;
    rx_one(8'h5A, 0, 0);
    hw(8'hC3);
    repeat (2) @(negedge clk);
    chk(host_rdata == 8'h5A, "R12 rdata after write", host_rdata, 8'h5A);
    cap_tx(8'hC3);
    repeat (20) @(negedge clk);

    // R4: byte written mid-frame follows directly
    begin
      int e0, d0;
      e0 = n_txe; d0 = n_txd;
      hw(8'h11);
      while (n_txe == e0) @(negedge clk);
      hw(8'hEE);
      cap_tx(8'h11);
      cap_tx(8'hEE);
      repeat (20) @(negedge clk);
      chk(n_txe == e0 + 2, "R4 two buffer moves", n_txe - e0, 2);
      chk(n_txd == d0 + 2, "R4 two frames done", n_txd - d0, 2);
    end

    // R5: transmit disabled holds the byte
    begin
      int e0;
      bit low;
      e0 = n_txe; low = 0;
      tx_on = 0;
      hw(8'h72);
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (!txd) low = 1; end
      chk(!low, "R5 line stays high", int'(low), 0);
      chk(n_txe == e0, "R5 no buffer move", n_txe - e0, 0);
      tx_on = 1;
      cap_tx(8'h72);
      repeat (20) @(negedge clk);
    end

    // R9: short glitch rejected
    begin
      int r0;
      r0 = n_rx;
      @(negedge clk); rxd = 0;
      repeat (4) @(negedge clk); rxd = 1;
      repeat (64) @(negedge clk);
      chk(n_rx == r0, "R9 glitch ignored", n_rx - r0, 0);
      rx_one(8'h33, 0, 0);
    end

    // R10: receive disabled
    begin
      int r0;
      r0 = n_rx;
      rx_on = 0;
      send_rx(8'hAA, 0, 0);
      chk(n_rx == r0, "R10 no rx_load", n_rx - r0, 0);
      chk(host_rdata == 8'h33, "R10 rdata kept", host_rdata, 8'h33);
      rx_on = 1;
      repeat (4) @(negedge clk);
    end

    // R11: global disable mid-frame
    begin
      bit low;
      low = 0;
      hw(8'h00);
      hw(8'hF0);
      repeat (40) @(negedge clk);
      chk(!txd, "R11 frame in flight", int'(txd), 0);
      port_on = 0;
      @(negedge clk);
      chk(txd === 1'b1, "R11 line high", int'(txd), 1);
      chk(host_rdata == 8'h00, "R11 rdata cleared", host_rdata, 0);
      @(negedge clk);
      port_on = 1;
      for (int i = 0; i < 400; i++) begin @(negedge clk); if (!txd) low = 1; end
      chk(!low, "R11 pending byte dropped", int'(low), 0);
    end

    done_run();
  end
endmodule